// File: doc/BRIEF.md
# Audio Sample Formatter FIFO

The block sits behind a single data register of an audio transmitter. Each 32-bit word written there holds one or two audio samples inside byte containers. The block picks out the sample bits according to a set of static mode inputs and turns each one into a signed 24-bit audio field. It stores that field, tagged with a channel, in an 8-entry transmit FIFO.

The mode inputs are:
- container size, one to four bytes;
- number of valid bits;
- byte order;
- justification of the valid bits inside the container;
- mono or dual channel operation;
- one of three access modes: per-write channel index, automatic left/right toggling, or two interleaved half-word samples per write.

A downstream frame encoder pops entries with a read strobe. It sees the head sample and its channel tag directly on the outputs.

The level outputs tell a DMA engine or driver when to write. Ready means at least one entry is free. The chunk flag means at least a programmable number of entries are free. Empty and full report the two extremes. Two sticky flags record a write that did not fit and a read from an empty queue. A clear input empties the queue. A soft-reset input returns every piece of state to its initial value.

The channel pointer used in toggle mode is a two-state machine:
- PTR_CH1 means the next toggled write goes to channel 1, tag 0.
- PTR_CH2 means the next toggled write goes to channel 2, tag 1.

It has three transitions:
- ADVANCE flips the state on every accepted toggled write in dual mode.
- HOLD keeps the state in every other cycle, including dropped writes and clear.
- RESTART forces PTR_CH1 on soft reset or power-on reset.

Top module: `smpfmt_fifo`

## Requirements
- R1: After rst_n or a soft_rst pulse the queue is empty: st_empty=1, st_ready=1, st_full=0. Both sticky flags are 0, and the channel pointer is in PTR_CH1, so the next toggled write carries tag 0.
- R2: The container is the low n = bytes_m1+1 bytes of the written word. With big_order=1 those n bytes are reversed first. The effective valid width v is vbits, except that 0 or a value above 8n is taken as 8n. With msb_just=0 the sample is the low v bits of the container; with msb_just=1 it is the top v bits. rd_sample holds the sample shifted left by 24-v when v<=24, or its top 24 bits when v>24.
- R3: In toggle access (acc_mode 1, or 3 treated the same) with dual_en=1, accepted writes get tags 0,1,0,1,... With dual_en=0 every toggled write gets tag 0.
- R4: In indexed access (acc_mode 0) each write is tagged with wr_chan, whatever dual_en is.
- R5: In interleaved access (acc_mode 2) one write pushes two entries. The first comes from bits 15:0 with tag 0, the second from bits 31:16 with tag 1. Each half is a container whose size is min(n,2) bytes.
- R6: Entries leave in write order. st_empty is 1 when the queue holds 0 entries, st_full is 1 at 8 entries, and st_ready is 1 when fewer than 8 are held.
- R7: st_chunk is 1 exactly when the number of free entries is at least chunk_sz, so chunk_sz=0 always gives 1.
- R8: A write that needs more entries than are free is dropped whole. It sets st_overrun, which stays set until soft reset, and it does not advance the channel pointer.
- R9: rd_en while the queue is empty sets st_underrun, which stays set until soft reset, and changes nothing else.
- R10: fifo_clr empties the queue in one cycle but keeps both sticky flags and the channel pointer. Writes and reads in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return of all state to initial values |
| fifo_clr | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Written data word |
| wr_chan | input | 1 | Channel tag used in indexed access |
| dual_en | input | 1 | 1 = two channels, 0 = mono |
| big_order | input | 1 | 1 = reverse container bytes |
| msb_just | input | 1 | 1 = valid bits at container top |
| vbits | input | 6 | Valid bits per sample |
| bytes_m1 | input | 2 | Container bytes minus one |
| acc_mode | input | 2 | 0 indexed, 1 toggle, 2 interleaved, 3 toggle |
| chunk_sz | input | 4 | Free-entry threshold for st_chunk |
| rd_en | input | 1 | Pop strobe |
| rd_sample | output | 24 | Head entry sample |
| rd_chan | output | 1 | Head entry channel tag |
| st_ready | output | 1 | At least one entry free |
| st_empty | output | 1 | No entries held |
| st_full | output | 1 | All entries held |
| st_chunk | output | 1 | Free entries >= chunk_sz |
| st_underrun | output | 1 | Sticky read-while-empty |
| st_overrun | output | 1 | Sticky dropped write |

## Verification
A wrong entry count shows on the level flags in the cycle right after the faulty update. The fill sweep compares the flags with the arithmetic level at every step and for every chunk threshold. A channel pointer left in the wrong state shows as a swapped tag on the next toggled write. This is exercised right after a dropped write, a clear and a soft reset. A mis-steered container byte or a wrong shift shows in the head sample one cycle after the write. The format sweep covers every container size, valid width, byte order and justification.

// File: rtl/smpfmt_pkg.sv
package smpfmt_pkg;

    localparam logic [1:0] ACC_INDEX   = 2'd0;
    localparam logic [1:0] ACC_TOGGLE  = 2'd1;
    localparam logic [1:0] ACC_PAIR    = 2'd2;
    localparam logic [1:0] ACC_TOGGLE3 = 2'd3;

    typedef enum logic {PTR_CH1 = 1'b0, PTR_CH2 = 1'b1} ptr_state_e;

    typedef struct packed {
        logic [23:0] smp;
        logic        ch;
    } fmt_entry_t;

    // Pull the valid field out of a container and left-align it to 24 bits.
    function automatic logic [23:0] fmt_extract(input logic [31:0] w,
                                                input int          nbytes,
                                                input logic [5:0]  vb,
                                                input logic        big,
                                                input logic        msb);
        int          cw;
        int          v;
        logic [31:0] c;
        logic [31:0] al;
        cw = nbytes * 8;
        v  = (vb == 6'd0 || int'(vb) > cw) ? cw : int'(vb);
        c  = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < nbytes)
                c[8*i +: 8] = big ? w[8*(nbytes-1-i) +: 8] : w[8*i +: 8];
        end
        if (msb)
            al = c << (32 - cw);
        else
            al = c << (32 - v);
        al = al & ~(32'hFFFF_FFFF >> v);
        return al[31:8];
    endfunction

endpackage

// File: rtl/smpfmt_unpack.sv
module smpfmt_unpack
    import smpfmt_pkg::*;
(
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        wr_chan,
    input  logic        tog_chan,
    input  logic        dual_en,
    input  logic        big_order,
    input  logic        msb_just,
    input  logic [5:0]  vbits,
    input  logic [1:0]  bytes_m1,
    input  logic [1:0]  acc_mode,
    output logic [1:0]  push_n,
    output fmt_entry_t  ent0,
    output fmt_entry_t  ent1
);
    int nb;
    int nb_half;

    always_comb begin
        nb      = int'(bytes_m1) + 1;
        nb_half = (nb > 2) ? 2 : nb;
        ent0    = '0;
        ent1    = '0;
        push_n  = 2'd0;
        unique case (acc_mode)
            ACC_INDEX: begin
                ent0.smp = fmt_extract(wr_data, nb, vbits, big_order, msb_just);
                ent0.ch  = wr_chan;
                push_n   = wr_en ? 2'd1 : 2'd0;
            end
            ACC_PAIR: begin
                ent0.smp = fmt_extract({16'h0, wr_data[15:0]}, nb_half, vbits, big_order, msb_just);
                ent0.ch  = 1'b0;
                ent1.smp = fmt_extract({16'h0, wr_data[31:16]}, nb_half, vbits, big_order, msb_just);
                ent1.ch  = 1'b1;
                push_n   = wr_en ? 2'd2 : 2'd0;
            end
            ACC_TOGGLE, ACC_TOGGLE3: begin
                ent0.smp = fmt_extract(wr_data, nb, vbits, big_order, msb_just);
                ent0.ch  = dual_en ? tog_chan : 1'b0;
                push_n   = wr_en ? 2'd1 : 2'd0;
            end
            default: push_n = 2'd0;
        endcase
    end
endmodule

// File: rtl/smpfmt_chan_fsm.sv
module smpfmt_chan_fsm
    import smpfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic advance,
    output logic chan
);
    ptr_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PTR_CH1: if (advance) state_nx = PTR_CH2;
            PTR_CH2: if (advance) state_nx = PTR_CH1;
            default: state_nx = PTR_CH1;
        endcase
        if (srst) state_nx = PTR_CH1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PTR_CH1;
        else        state <= state_nx;
    end

    always_comb begin
        chan = (state == PTR_CH2);
    end

    assert_ptr_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state == PTR_CH1));

    assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !srst) |=> (state != $past(state)));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !srst) |=> $stable(state));
endmodule

// File: rtl/smpfmt_ring.sv
module smpfmt_ring
    import smpfmt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       srst,
    input  logic                       clr,
    input  logic [1:0]                 push_n,
    input  fmt_entry_t                 ent0,
    input  fmt_entry_t                 ent1,
    input  logic                       pop,
    output fmt_entry_t                 head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       accept,
    output logic                       ovf,
    output logic                       udr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    fmt_entry_t      mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   free_n;
    logic            do_push, do_pop, idle;

    always_comb begin
        free_n  = CW'(DEPTH) - count;
        accept  = (CW'(push_n) <= free_n);
        idle    = clr || srst;
        do_push = (push_n != 2'd0) && accept && !idle;
        do_pop  = pop && (count != '0) && !idle;
        head    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= ent0;
            if (push_n == 2'd2) mem[wp + AW'(1)] <= ent1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0; udr <= 1'b0;
        end else if (srst) begin
            wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0; udr <= 1'b0;
        end else if (clr) begin
            wp <= '0; rp <= '0; count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(push_n);
            if (do_pop)  rp <= rp + AW'(1);
            count <= count + (do_push ? CW'(push_n) : CW'(0)) - (do_pop ? CW'(1) : CW'(0));
            if (push_n != 2'd0 && !accept) ovf <= 1'b1;
            if (pop && count == '0)        udr <= 1'b1;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_drop_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0 && !accept && !pop && !clr && !srst) |=> ($stable(count) && ovf));

    assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !clr && !srst) |=> (udr && count == '0));

    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (udr && !srst) |=> udr);

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !srst) |=> (count == '0 && ovf == $past(ovf) && udr == $past(udr)));
endmodule

// File: rtl/smpfmt_fifo.sv
module smpfmt_fifo
    import smpfmt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        fifo_clr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        wr_chan,
    input  logic        dual_en,
    input  logic        big_order,
    input  logic        msb_just,
    input  logic [5:0]  vbits,
    input  logic [1:0]  bytes_m1,
    input  logic [1:0]  acc_mode,
    input  logic [3:0]  chunk_sz,
    input  logic        rd_en,
    output logic [23:0] rd_sample,
    output logic        rd_chan,
    output logic        st_ready,
    output logic        st_empty,
    output logic        st_full,
    output logic        st_chunk,
    output logic        st_underrun,
    output logic        st_overrun
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic           tog_chan, accept, advance, is_toggle;
    logic [1:0]     push_n;
    fmt_entry_t     ent0, ent1, head;
    logic [CW-1:0]  count;

    smpfmt_unpack u_unpack (
        .wr_en(wr_en), .wr_data(wr_data), .wr_chan(wr_chan), .tog_chan(tog_chan),
        .dual_en(dual_en), .big_order(big_order), .msb_just(msb_just),
        .vbits(vbits), .bytes_m1(bytes_m1), .acc_mode(acc_mode),
        .push_n(push_n), .ent0(ent0), .ent1(ent1)
    );

    smpfmt_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .clr(fifo_clr),
        .push_n(push_n), .ent0(ent0), .ent1(ent1), .pop(rd_en),
        .head(head), .count(count), .accept(accept),
        .ovf(st_overrun), .udr(st_underrun)
    );

    always_comb begin
        is_toggle = (acc_mode == ACC_TOGGLE) || (acc_mode == ACC_TOGGLE3);
        advance   = wr_en && is_toggle && dual_en && accept && !fifo_clr && !soft_rst;
    end

    smpfmt_chan_fsm u_ptr (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst), .advance(advance), .chan(tog_chan)
    );

    always_comb begin
        rd_sample = head.smp;
        rd_chan   = head.ch;
        st_empty  = (count == '0);
        st_full   = (count == CW'(DEPTH));
        st_ready  = (count < CW'(DEPTH));
        st_chunk  = (int'(CW'(DEPTH) - count) >= int'(chunk_sz));
    end

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_empty && st_full) && (st_ready != st_full));

    assert_soft_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_empty && !st_overrun && !st_underrun));
endmodule

// File: tb/smpfmt_fifo_test.sv
module smpfmt_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n, soft_rst, fifo_clr, wr_en, wr_chan, dual_en, big_order, msb_just, rd_en;
    logic [31:0] wr_data;
    logic [5:0]  vbits;
    logic [1:0]  bytes_m1, acc_mode;
    logic [3:0]  chunk_sz;
    logic [23:0] rd_sample;
    logic        rd_chan, st_ready, st_empty, st_full, st_chunk, st_underrun, st_overrun;
    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smpfmt_fifo uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input longint w, input int n, input int vb,
                                          input bit big, input bit msb);
        longint c = 0;
        longint fld;
        int cw = 8 * n;
        int v  = (vb == 0 || vb > cw) ? cw : vb;
        for (int i = 0; i < n; i++) begin
            longint b = big ? ((w >> (8 * (n - 1 - i))) & 255) : ((w >> (8 * i)) & 255);
            c = c + (b << (8 * i));
        end
        fld = msb ? (c >> (cw - v)) : (c & ((longint'(1) << v) - 1));
        if (v <= 24) return 24'((fld << (24 - v)) & 64'hFF_FFFF);
        return 24'(fld >> (v - 24));
    endfunction

    task automatic wr(input logic [31:0] d, input logic ch);
        wr_data = d; wr_chan = ch; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic srst();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic fmt(input int nb, input int vb, input bit big, input bit msb,
                       input int acc, input bit dual);
        bytes_m1 = 2'(nb - 1); vbits = 6'(vb); big_order = big; msb_just = msb;
        acc_mode = 2'(acc); dual_en = dual;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int vbl [8] = '{0, 8, 12, 16, 18, 20, 24, 32};
        logic [31:0] d;
        rst_n = 1'b0; soft_rst = 0; fifo_clr = 0; wr_en = 0; wr_chan = 0; rd_en = 0;
        wr_data = '0; chunk_sz = 4'd8;
        fmt(1, 8, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 empty", st_empty, 1); chk("R1 ready", st_ready, 1); chk("R1 full", st_full, 0);
        chk("R1 chunk", st_chunk, 1); chk("R1 udr", st_underrun, 0); chk("R1 ovr", st_overrun, 0);

        // R2 format sweep
        for (int n = 1; n <= 4; n++)
            for (int vi = 0; vi < 8; vi++)
                for (int bg = 0; bg < 2; bg++)
                    for (int ms = 0; ms < 2; ms++)
                        for (int k = 0; k < 2; k++) begin
                            d = k ? (32'h9E37_79B9 * 32'(n * 64 + vi * 4 + bg * 2 + ms + 1)) : 32'hA5C3_1E97;
                            fmt(n, vbl[vi], bit'(bg), bit'(ms), 1, 0);
                            wr(d, 0);
                            chk("R2 sample", rd_sample, model(d, n, vbl[vi], bit'(bg), bit'(ms)));
                            chk("R3 mono tag", rd_chan, 0);
                            rd();
                        end

        // R6 / R7 level sweep, R8 overrun
        srst();
        fmt(1, 8, 0, 0, 1, 0);
        for (int k = 0; k <= 8; k++) begin
            for (int cs = 0; cs < 16; cs++) begin
                chunk_sz = 4'(cs); #1;
                chk("R7 chunk", st_chunk, 32'((8 - k) >= cs));
            end
            chk("R6 empty", st_empty, 32'(k == 0)); chk("R6 full", st_full, 32'(k == 8));
            chk("R6 ready", st_ready, 32'(k < 8));
            if (k < 8) wr(32'(k * 17 + 3), 0);
        end
        wr(32'hEE, 0);
        chk("R8 overrun", st_overrun, 1); chk("R8 full", st_full, 1);
        for (int k = 0; k < 8; k++) begin
            chk("R6 order", rd_sample, model(k * 17 + 3, 1, 8, 0, 0));
            rd();
        end
        chk("R6 drained", st_empty, 1); chk("R9 no udr", st_underrun, 0);
        chk("R8 sticky", st_overrun, 1);

        // R3 toggle + R8 pointer holds on drop
        srst();
        fmt(2, 16, 0, 0, 1, 1);
        for (int k = 0; k < 8; k++) wr(32'(k + 1), 0);
        wr(32'h7777, 0);
        rd();
        wr(32'h55, 0);
        for (int k = 1; k < 8; k++) begin
            chk("R3 toggle tag", rd_chan, 32'(k % 2));
            chk("R6 toggle data", rd_sample, model(k + 1, 2, 16, 0, 0));
            rd();
        end
        chk("R8 ptr held tag", rd_chan, 0);
        chk("R8 ptr held data", rd_sample, model(32'h55, 2, 16, 0, 0));
        rd();

        // R4 indexed
        fmt(3, 24, 1, 0, 0, 1);
        wr(32'h0012_3456, 1); wr(32'h00AB_CDEF, 0);
        chk("R4 tag1", rd_chan, 1); chk("R4 data", rd_sample, model(32'h0012_3456, 3, 24, 1, 0)); rd();
        chk("R4 tag0", rd_chan, 0); chk("R4 data", rd_sample, model(32'h00AB_CDEF, 3, 24, 1, 0)); rd();

        // R5 interleaved
        for (int bg = 0; bg < 2; bg++) begin
            fmt(4, 16, bit'(bg), 0, 2, 0);
            wr(32'h8001_7FFE, 0);
            chk("R5 first tag", rd_chan, 0);
            chk("R5 first", rd_sample, model(32'h7FFE, 2, 16, bit'(bg), 0)); rd();
            chk("R5 second tag", rd_chan, 1);
            chk("R5 second", rd_sample, model(32'h8001, 2, 16, bit'(bg), 0)); rd();
            chk("R5 drained", st_empty, 1);
        end
        // R5/R8 interleaved needing two slots with one free
        srst();
        fmt(1, 8, 0, 0, 1, 0);
        for (int k = 0; k < 7; k++) wr(32'(k), 0);
        fmt(1, 8, 0, 0, 2, 0);
        wr(32'h1234_5678, 0);
        chk("R8 pair drop", st_overrun, 1);
        chunk_sz = 4'd1; #1; chk("R8 level kept", st_chunk, 1);
        chunk_sz = 4'd2; #1; chk("R8 level kept", st_chunk, 0);

        // R9 underrun, R10 clear
        srst();
        chk("R1 soft reset ovr", st_overrun, 0);
        rd();
        chk("R9 underrun", st_underrun, 1); chk("R9 still empty", st_empty, 1);
        repeat (3) @(negedge clk);
        chk("R9 sticky", st_underrun, 1);
        fmt(1, 8, 0, 0, 1, 1);
        wr(32'h11, 0); wr(32'h22, 0); wr(32'h33, 0);
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
        chk("R10 empty", st_empty, 1); chk("R10 udr kept", st_underrun, 1);
        wr(32'h44, 0);
        chk("R10 ptr kept", rd_chan, 1); chk("R10 data", rd_sample, model(32'h44, 1, 8, 0, 0));
        srst();
        chk("R1 udr cleared", st_underrun, 0); chk("R1 empty", st_empty, 1);
        wr(32'h66, 0);
        chk("R1 ptr home", rd_chan, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule